// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one autonomous copy channel. Software programs a source address, a destination address, an item count and a control word through a small word-indexed register port, then sets the enable bit. The channel asks an external arbiter for the system bus, waits for the grant, and moves items one at a time through a single-beat valid/ready master port. Each item is a read from the source followed by a write to the destination. When the count runs out, the channel drops its bus request and then raises a completion flag.

The control word has a direction bit that chooses which side is the peripheral. It has separate increment enables and item sizes for the peripheral side and the memory side, and a burst length that sets how many items are moved under one bus request. Circular mode reloads the programmed addresses and count at the end of each pass and keeps the channel running. Three sticky flags (complete, half-way, error) each drive the interrupt line when their own enable bit is set. A two-bit priority field is stored and presented on a port for an external arbiter.

The register index on `cfg_addr` is 0 control, 1 status, 2 source, 3 destination, 4 count. Reads are combinational.

Top module: `dma_mover`

## Requirements
- R1: After reset, every register reads 0, `bus_req` and `irq` are low and no bus traffic occurs.
- R2: While control bit 0 (enable) is 1, writes to source, destination and count have no effect. A control write in that state can only clear bit 0; every other control bit is kept.
- R3: Item k reads from source base + k·step and writes to destination base + k·step. The step of a side is its item size in bytes when its increment bit is set, otherwise 0. Written data is the read data zero-extended from the source item size. Control bit 4 = 0 makes the source the peripheral side (bit 6 increment, size in bits 9:8) and the destination the memory side (bit 7 increment, size in bits 11:10); bit 4 = 1 swaps the two sides.
- R4: Size codes 00/01/10 mean 1/2/4 bytes (11 acts as 4). `m_size` carries the source size during reads and the destination size during writes.
- R5: Control bits 17:16 = 00/01/10 select 4/8/16 items per bus request (11 selects 4). `bus_req` stays high for at most that many items, and is dropped and raised again between bursts.
- R6: The complete flag (status bit 1) rises only after `bus_req` has been low for a cycle.
- R7: Outside circular mode, the channel clears its own enable bit when the last item is written and sets the complete flag.
- R8: The half flag (status bit 2) sets when item floor(count/2) has been written, for count ≥ 2.
- R9: In circular mode (control bit 5), the end of the count sets the complete flag, keeps enable at 1, and restarts at the programmed addresses. Clearing enable stops the channel at the next item boundary.
- R10: Enabling with a count of 0 sets the complete flag and clears enable without any bus transaction.
- R11: An `m_err` response sets the error flag (status bit 3), clears enable and drops `bus_req`.
- R12: A source or destination address that is not aligned to its item size sets the error flag before any transaction is issued.
- R13: A status write clears each flag whose bit is written 0 and keeps each flag whose bit is written 1. `irq` is high exactly when a set flag has its enable bit set (bits 1, 2, 3 of control for complete, half, error).
- R14: Control bits 13:12 are stored and presented on `chan_prio`. Undefined control bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| chan_prio | output | 2 | Stored priority level |
| m_valid | output | 1 | Master transaction valid |
| m_write | output | 1 | 1 = write, 0 = read |
| m_addr | output | AW | Byte address |
| m_size | output | 2 | Item size code |
| m_wdata | output | DW | Write data |
| m_ready | input | 1 | Transaction accepted / read data valid |
| m_rdata | input | DW | Read data |
| m_err | input | 1 | Error response, qualified by `m_ready` |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every combination of direction, both increment bits and the three item sizes on each side. Count (1 to 6) and burst code rotate across the sweep, and every read and write address, data word and size is compared with arithmetic expectations. This separates a swapped peripheral/memory mapping, a wrong step width and a wrong zero-extension mask. Over the same sweep, the longest bus-request window is compared with min(burst, count), and the interrupt line, with only the half enable set, is compared with the expected half point after every write. Directed runs then cover frozen configuration, zero count, a bus error part-way through, a misaligned start, circular reload with a later stop, selective flag clearing, and priority readback.

// File: rtl/dma_mover_pkg.sv
// Shared constants, types and helpers for the single-channel mover.
// Assumes a 3-bit word index for the register port.
package dma_mover_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_REQ, S_RD, S_WR, S_GAP, S_FIN, S_ERR
    } seq_state_e;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_STAT = 3'd1;
    localparam logic [2:0] A_SRC  = 3'd2;
    localparam logic [2:0] A_DST  = 3'd3;
    localparam logic [2:0] A_CNT  = 3'd4;

    localparam int B_EN   = 0;
    localparam int B_TCIE = 1;
    localparam int B_HTIE = 2;
    localparam int B_TEIE = 3;
    localparam int B_DIR  = 4;
    localparam int B_CIRC = 5;
    localparam int B_PINC = 6;
    localparam int B_MINC = 7;
    localparam int B_PSZ  = 8;
    localparam int B_MSZ  = 10;
    localparam int B_PRIO = 12;
    localparam int B_BST  = 16;

    localparam logic [31:0] CTRL_MASK = 32'h0003_3FFF;

    localparam int F_TC = 1;
    localparam int F_HT = 2;
    localparam int F_TE = 3;

    // Bytes per item for a size code; the spare code acts as the widest.
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'b00:   return 3'd1;
            2'b01:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // Items per bus request for a burst code; the spare code acts as 4.
    function automatic logic [4:0] burst_items(input logic [1:0] bc);
        case (bc)
            2'b01:   return 5'd8;
            2'b10:   return 5'd16;
            default: return 5'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_mover_step.sv
// Address stepper for one side of the channel: next address and alignment.
// Assumes byte addresses; a side without increment keeps its address.
module dma_mover_step
    import dma_mover_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur_addr,
    input  logic          incr,
    input  logic [1:0]    size,
    output logic [AW-1:0] next_addr,
    output logic          misaligned
);
    logic [2:0] nbytes;
    logic [1:0] low_mask;

    // Step width and low-bit mask derived from the size code.
    always_comb begin
        nbytes     = size_bytes(size);
        low_mask   = 2'(nbytes - 3'd1);
        next_addr  = incr ? (cur_addr + AW'(nbytes)) : cur_addr;
        misaligned = |(cur_addr[1:0] & low_mask);
    end
endmodule

// File: rtl/dma_mover_regs.sv
// Register file: control, sticky flags, addresses, count and the interrupt.
// Assumes the sequencer pulses set_* and clr_en for one cycle.
module dma_mover_regs
    import dma_mover_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [2:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          set_tc,
    input  logic          set_ht,
    input  logic          set_te,
    input  logic          clr_en,
    output logic          en,
    output logic          dir,
    output logic          circ,
    output logic          pinc,
    output logic          minc,
    output logic [1:0]    psize,
    output logic [1:0]    msize,
    output logic [1:0]    burst,
    output logic [1:0]    prio,
    output logic [AW-1:0] src_base,
    output logic [AW-1:0] dst_base,
    output logic [CW-1:0] cnt_base,
    output logic          flag_tc,
    output logic          flag_te,
    output logic          irq
);
    logic [31:0]   ctrl_q;
    logic [AW-1:0] src_q, dst_q;
    logic [CW-1:0] cnt_q;
    logic          tc_q, ht_q, te_q;
    logic          wr_ctrl, wr_stat, cfg_open;

    assign wr_ctrl  = cfg_wr && (cfg_addr == A_CTRL);
    assign wr_stat  = cfg_wr && (cfg_addr == A_STAT);
    assign cfg_open = !ctrl_q[B_EN];

    // Control word: fully writable when idle, only the enable bit is clearable when running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) begin
                if (cfg_open) ctrl_q <= cfg_wdata & CTRL_MASK;
                else          ctrl_q[B_EN] <= ctrl_q[B_EN] & cfg_wdata[B_EN];
            end
            if (clr_en) ctrl_q[B_EN] <= 1'b0;
        end
    end

    // Transfer parameters, frozen while the channel is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
        end else if (cfg_wr && cfg_open) begin
            if (cfg_addr == A_SRC) src_q <= cfg_wdata[AW-1:0];
            if (cfg_addr == A_DST) dst_q <= cfg_wdata[AW-1:0];
            if (cfg_addr == A_CNT) cnt_q <= cfg_wdata[CW-1:0];
        end
    end

    // Sticky flags: hardware sets win, software clears with a 0 bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q <= 1'b0;
            ht_q <= 1'b0;
            te_q <= 1'b0;
        end else begin
            tc_q <= (tc_q & (!wr_stat || cfg_wdata[F_TC])) | set_tc;
            ht_q <= (ht_q & (!wr_stat || cfg_wdata[F_HT])) | set_ht;
            te_q <= (te_q & (!wr_stat || cfg_wdata[F_TE])) | set_te;
        end
    end

    // Combinational register readback.
    always_comb begin
        case (cfg_addr)
            A_CTRL:  cfg_rdata = ctrl_q;
            A_STAT:  cfg_rdata = {28'd0, te_q, ht_q, tc_q, 1'b0};
            A_SRC:   cfg_rdata = 32'(src_q);
            A_DST:   cfg_rdata = 32'(dst_q);
            A_CNT:   cfg_rdata = 32'(cnt_q);
            default: cfg_rdata = '0;
        endcase
    end

    // Field decode and interrupt combination.
    always_comb begin
        en       = ctrl_q[B_EN];
        dir      = ctrl_q[B_DIR];
        circ     = ctrl_q[B_CIRC];
        pinc     = ctrl_q[B_PINC];
        minc     = ctrl_q[B_MINC];
        psize    = ctrl_q[B_PSZ +: 2];
        msize    = ctrl_q[B_MSZ +: 2];
        prio     = ctrl_q[B_PRIO +: 2];
        burst    = ctrl_q[B_BST +: 2];
        src_base = src_q;
        dst_base = dst_q;
        cnt_base = cnt_q;
        flag_tc  = tc_q;
        flag_te  = te_q;
        irq      = (tc_q & ctrl_q[B_TCIE]) | (ht_q & ctrl_q[B_HTIE]) | (te_q & ctrl_q[B_TEIE]);
    end

    p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[B_EN] && cfg_wr && (cfg_addr == A_SRC)) |=> $stable(src_q));

    p_self_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tc_q) && !ctrl_q[B_CIRC]) |-> !ctrl_q[B_EN]);

    p_flag_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && (cfg_wdata[3:1] == 3'b000) && !set_tc && !set_ht && !set_te)
        |=> (!tc_q && !ht_q && !te_q));
endmodule

// File: rtl/dma_mover_seq.sv
// Transfer sequencer: bus request/grant, read-then-write beats, bursts,
// circular reload and flag pulses. Assumes the grant stays high while requested.
module dma_mover_seq
    import dma_mover_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          dir,
    input  logic          circ,
    input  logic          pinc,
    input  logic          minc,
    input  logic [1:0]    psize,
    input  logic [1:0]    msize,
    input  logic [1:0]    burst,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    input  logic [CW-1:0] cnt_base,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          m_valid,
    output logic          m_write,
    output logic [AW-1:0] m_addr,
    output logic [1:0]    m_size,
    output logic [DW-1:0] m_wdata,
    input  logic          m_ready,
    input  logic [DW-1:0] m_rdata,
    input  logic          m_err,
    output logic          set_tc,
    output logic          set_ht,
    output logic          set_te,
    output logic          clr_en
);
    seq_state_e    state;
    logic [AW-1:0] src_a, dst_a, src_nx, dst_nx;
    logic [CW-1:0] remain, done, total;
    logic [4:0]    beat, blen;
    logic [DW-1:0] data_q, rd_mask;
    logic          src_inc, dst_inc, src_mis, dst_mis, mis;
    logic [1:0]    src_sz, dst_sz;
    logic [2:0]    src_nb;
    logic          rd_ok, wr_ok, keep_running;

    // Map the peripheral and memory sides onto source and destination.
    always_comb begin
        src_inc = dir ? minc  : pinc;
        src_sz  = dir ? msize : psize;
        dst_inc = dir ? pinc  : minc;
        dst_sz  = dir ? psize : msize;
        blen    = burst_items(burst);
        src_nb  = size_bytes(src_sz);
        rd_mask = (src_nb == 3'd4) ? '1 : ((DW'(1) << (8 * src_nb)) - DW'(1));
        mis     = src_mis | dst_mis;
    end

    dma_mover_step #(.AW(AW)) u_src_step (
        .cur_addr (src_a),
        .incr     (src_inc),
        .size     (src_sz),
        .next_addr(src_nx),
        .misaligned(src_mis)
    );

    dma_mover_step #(.AW(AW)) u_dst_step (
        .cur_addr (dst_a),
        .incr     (dst_inc),
        .size     (dst_sz),
        .next_addr(dst_nx),
        .misaligned(dst_mis)
    );

    assign rd_ok        = (state == S_RD) && !mis && m_ready && !m_err;
    assign wr_ok        = (state == S_WR) && m_ready && !m_err;
    assign keep_running = circ && en && (total != '0);

    // Main state register, working addresses, counters and data holding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            src_a  <= '0;
            dst_a  <= '0;
            remain <= '0;
            done   <= '0;
            total  <= '0;
            beat   <= '0;
            data_q <= '0;
        end else begin
            case (state)
                S_IDLE: if (en) begin
                    src_a  <= src_base;
                    dst_a  <= dst_base;
                    remain <= cnt_base;
                    total  <= cnt_base;
                    done   <= '0;
                    state  <= (cnt_base == '0) ? S_FIN : S_REQ;
                end
                S_REQ: begin
                    beat <= '0;
                    if (!en)         state <= S_IDLE;
                    else if (bus_gnt) state <= S_RD;
                end
                S_RD: begin
                    if (mis) state <= S_ERR;
                    else if (m_ready) begin
                        if (m_err) state <= S_ERR;
                        else begin
                            data_q <= m_rdata & rd_mask;
                            state  <= S_WR;
                        end
                    end
                end
                S_WR: if (m_ready) begin
                    if (m_err) state <= S_ERR;
                    else begin
                        src_a  <= src_nx;
                        dst_a  <= dst_nx;
                        remain <= remain - CW'(1);
                        done   <= done + CW'(1);
                        beat   <= beat + 5'd1;
                        if (remain == CW'(1))           state <= S_FIN;
                        else if (!en)                   state <= S_IDLE;
                        else if (beat == blen - 5'd1)   state <= S_GAP;
                        else                            state <= S_RD;
                    end
                end
                S_GAP: state <= en ? S_REQ : S_IDLE;
                S_FIN: begin
                    if (keep_running) begin
                        src_a  <= src_base;
                        dst_a  <= dst_base;
                        remain <= total;
                        done   <= '0;
                        state  <= S_REQ;
                    end else begin
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Bus-side outputs and single-cycle flag pulses.
    always_comb begin
        bus_req = (state == S_REQ) || (state == S_RD) || (state == S_WR);
        m_valid = ((state == S_RD) && !mis) || (state == S_WR);
        m_write = (state == S_WR);
        m_addr  = (state == S_WR) ? dst_a : src_a;
        m_size  = (state == S_WR) ? dst_sz : src_sz;
        m_wdata = data_q;
        set_tc  = (state == S_FIN);
        set_ht  = wr_ok && ((done + CW'(1)) == (total >> 1));
        set_te  = (state == S_ERR);
        clr_en  = (state == S_ERR) || ((state == S_FIN) && !keep_running);
    end

    p_hold_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write)));

    p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |=> (m_valid && m_write));
endmodule

// File: rtl/dma_mover.sv
// Top of the single-channel mover: register file plus transfer sequencer.
// Assumes an external arbiter drives bus_gnt and a single-beat slave answers m_valid.
module dma_mover
    import dma_mover_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [2:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [1:0]    chan_prio,
    output logic          m_valid,
    output logic          m_write,
    output logic [AW-1:0] m_addr,
    output logic [1:0]    m_size,
    output logic [DW-1:0] m_wdata,
    input  logic          m_ready,
    input  logic [DW-1:0] m_rdata,
    input  logic          m_err,
    output logic          irq
);
    logic          en, dir, circ, pinc, minc;
    logic [1:0]    psize, msize, burst;
    logic [AW-1:0] src_base, dst_base;
    logic [CW-1:0] cnt_base;
    logic          set_tc, set_ht, set_te, clr_en;
    logic          flag_tc, flag_te;

    dma_mover_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .set_tc   (set_tc),
        .set_ht   (set_ht),
        .set_te   (set_te),
        .clr_en   (clr_en),
        .en       (en),
        .dir      (dir),
        .circ     (circ),
        .pinc     (pinc),
        .minc     (minc),
        .psize    (psize),
        .msize    (msize),
        .burst    (burst),
        .prio     (chan_prio),
        .src_base (src_base),
        .dst_base (dst_base),
        .cnt_base (cnt_base),
        .flag_tc  (flag_tc),
        .flag_te  (flag_te),
        .irq      (irq)
    );

    dma_mover_seq #(.AW(AW), .DW(DW), .CW(CW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .dir     (dir),
        .circ    (circ),
        .pinc    (pinc),
        .minc    (minc),
        .psize   (psize),
        .msize   (msize),
        .burst   (burst),
        .src_base(src_base),
        .dst_base(dst_base),
        .cnt_base(cnt_base),
        .bus_req (bus_req),
        .bus_gnt (bus_gnt),
        .m_valid (m_valid),
        .m_write (m_write),
        .m_addr  (m_addr),
        .m_size  (m_size),
        .m_wdata (m_wdata),
        .m_ready (m_ready),
        .m_rdata (m_rdata),
        .m_err   (m_err),
        .set_tc  (set_tc),
        .set_ht  (set_ht),
        .set_te  (set_te),
        .clr_en  (clr_en)
    );

    p_release_before_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_tc) |-> $past(!bus_req));

    p_error_releases_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_te) |-> (!bus_req && !en));
endmodule

// File: tb/dma_mover_bench.sv
`timescale 1ns/1ps
module dma_mover_bench;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_addr = 3'd0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic [1:0]    chan_prio;
    logic          m_valid, m_write;
    logic [AW-1:0] m_addr;
    logic [1:0]    m_size;
    logic [DW-1:0] m_wdata;
    logic          m_ready = 1'b0;
    logic [DW-1:0] m_rdata = '0;
    logic          m_err = 1'b0;
    logic          irq;

    always #2.5 clk = ~clk;

    dma_mover #(.AW(AW), .DW(DW), .CW(CW)) u_dma_mover (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .chan_prio(chan_prio), .m_valid(m_valid),
        .m_write(m_write), .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata),
        .m_ready(m_ready), .m_rdata(m_rdata), .m_err(m_err), .irq(irq)
    );

    int checks = 0;
    int errors = 0;

    // Expectations for the running transfer.
    logic [31:0] e_src0 = '0, e_dst0 = '0;
    int e_sstep = 0, e_dstep = 0, e_ssz = 0, e_dsz = 0, e_total = 1;
    bit e_htchk = 1'b0;
    int nrd = 0, nwr = 0, win = 0, maxwin = 0, err_at_rd = -1;
    bit prev_req = 1'b0;
    logic        cap_w = 1'b0;
    logic [31:0] cap_a = '0, cap_d = '0;
    logic [1:0]  cap_s = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rdfun(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h3C3C0F0F;
    endfunction

    function automatic int nbytes(input int sz);
        return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] szmask(input int sz);
        return (sz == 0) ? 32'h0000_00FF : (sz == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    // Slave, arbiter and window monitor, all driven away from the active edge.
    always @(negedge clk) begin : slave
        int k;
        if (m_ready) begin
            k = (e_total > 0) ? ((cap_w ? nwr : nrd) % e_total) : 0;
            if (cap_w) begin
                if (!m_err) begin
                    chk("R3 write address", cap_a, e_dst0 + 32'(k * e_dstep));
                    chk("R3 write data", cap_d, rdfun(e_src0 + 32'(k * e_sstep)) & szmask(e_ssz));
                    chk("R4 write size", {30'd0, cap_s}, 32'(e_dsz));
                    nwr++;
                    win++;
                    if (e_htchk)
                        chk("R8 half flag irq", {31'd0, irq},
                            32'((nwr >= e_total / 2) && (e_total >= 2)));
                end
            end else begin
                chk("R3 read address", cap_a, e_src0 + 32'(k * e_sstep));
                chk("R4 read size", {30'd0, cap_s}, 32'(e_ssz));
                nrd++;
            end
            m_ready = 1'b0;
            m_err   = 1'b0;
        end else if (m_valid) begin
            cap_w   = m_write;
            cap_a   = m_addr;
            cap_d   = m_wdata;
            cap_s   = m_size;
            m_rdata = rdfun(m_addr);
            m_err   = !m_write && (nrd == err_at_rd);
            m_ready = 1'b1;
        end
        if (!bus_req && prev_req) begin
            if (win > maxwin) maxwin = win;
            win = 0;
        end
        prev_req = bus_req;
        bus_gnt  = bus_req;
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_addr = 3'd0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
        cfg_addr = 3'd0;
    endtask

    task automatic start_run(input int dir, input int pinc, input int minc, input int psz,
                             input int msz, input int cnt, input int bst,
                             input logic [31:0] src, input logic [31:0] dst,
                             input logic [31:0] extra);
        e_src0  = src;
        e_dst0  = dst;
        e_ssz   = dir ? msz : psz;
        e_dsz   = dir ? psz : msz;
        e_sstep = (dir ? minc : pinc) ? nbytes(e_ssz) : 0;
        e_dstep = (dir ? pinc : minc) ? nbytes(e_dsz) : 0;
        e_total = cnt;
        nrd = 0; nwr = 0; win = 0; maxwin = 0;
        wr(3'd2, src);
        wr(3'd3, dst);
        wr(3'd4, 32'(cnt));
        wr(3'd1, 32'd0);
        wr(3'd0, 32'd1 | (32'(dir) << 4) | (32'(pinc) << 6) | (32'(minc) << 7) |
                 (32'(psz) << 8) | (32'(msz) << 10) | (32'(bst) << 16) | extra);
    endtask

    task automatic wait_stop();
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            #1;
            if (cfg_rdata[0] == 1'b0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        int idx, blen, saved;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(3'd0, v); chk("R1 ctrl after reset", v, 32'd0);
        rd(3'd1, v); chk("R1 status after reset", v, 32'd0);
        rd(3'd2, v); chk("R1 source after reset", v, 32'd0);
        rd(3'd4, v); chk("R1 count after reset", v, 32'd0);
        chk("R1 bus_req after reset", {31'd0, bus_req}, 32'd0);
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        chk("R1 no traffic after reset", 32'(nrd + nwr), 32'd0);

        // R3 R4 R5 R7 R8: sweep of direction, increments and both sizes
        idx = 0;
        e_htchk = 1'b1;
        for (int d = 0; d < 2; d++)
            for (int pi = 0; pi < 2; pi++)
                for (int mi = 0; mi < 2; mi++)
                    for (int ps = 0; ps < 3; ps++)
                        for (int ms = 0; ms < 3; ms++) begin
                            int cnt, bst;
                            cnt  = 1 + (idx % 6);
                            bst  = idx % 4;
                            blen = (bst == 1) ? 8 : (bst == 2) ? 16 : 4;
                            start_run(d, pi, mi, ps, ms, cnt, bst,
                                      32'h1000 + 32'(idx * 64), 32'h8000 + 32'(idx * 32), 32'h4);
                            wait_stop();
                            chk("R7 item count", 32'(nwr), 32'(cnt));
                            rd(3'd0, v); chk("R7 enable self-cleared", {31'd0, v[0]}, 32'd0);
                            rd(3'd1, v); chk("R6 complete flag", {31'd0, v[1]}, 32'd1);
                            chk("R6 bus released", {31'd0, bus_req}, 32'd0);
                            chk("R5 burst window", 32'(maxwin), 32'((cnt < blen) ? cnt : blen));
                            idx++;
                        end
        e_htchk = 1'b0;

        // R5: long runs with 16- and 8-item bursts
        start_run(0, 1, 1, 2, 2, 20, 2, 32'h4000, 32'h5000, 32'h0);
        wait_stop();
        chk("R5 16-item burst window", 32'(maxwin), 32'd16);
        start_run(1, 1, 1, 2, 2, 20, 1, 32'h4000, 32'h5000, 32'h0);
        wait_stop();
        chk("R5 8-item burst window", 32'(maxwin), 32'd8);

        // R2: configuration frozen while enabled
        start_run(0, 1, 1, 2, 2, 40, 0, 32'h2000, 32'h3000, 32'h0);
        repeat (10) @(negedge clk);
        wr(3'd2, 32'hDEAD_0000);
        wr(3'd4, 32'd5);
        wr(3'd0, 32'h0000_0F01);
        wait_stop();
        rd(3'd2, v); chk("R2 source kept", v, 32'h2000);
        rd(3'd4, v); chk("R2 count kept", v, 32'd40);
        rd(3'd0, v); chk("R2 control kept", v, 32'h0000_0AC0);
        chk("R2 full count moved", 32'(nwr), 32'd40);

        // R10: zero count
        start_run(0, 1, 1, 2, 2, 0, 0, 32'h100, 32'h200, 32'h2);
        wait_stop();
        chk("R10 no traffic", 32'(nrd + nwr), 32'd0);
        rd(3'd1, v); chk("R10 complete flag", v, 32'h2);
        rd(3'd0, v); chk("R10 enable cleared", {31'd0, v[0]}, 32'd0);
        chk("R10 irq", {31'd0, irq}, 32'd1);

        // R11: bus error on the third read
        err_at_rd = 2;
        start_run(0, 1, 1, 2, 2, 6, 0, 32'h600, 32'h700, 32'h8);
        wait_stop();
        err_at_rd = -1;
        rd(3'd1, v); chk("R11 error flag only", v, 32'h8);
        chk("R11 writes before error", 32'(nwr), 32'd2);
        rd(3'd0, v); chk("R11 enable cleared", {31'd0, v[0]}, 32'd0);
        chk("R11 bus released", {31'd0, bus_req}, 32'd0);
        chk("R11 irq", {31'd0, irq}, 32'd1);

        // R12: misaligned 16-bit source, error interrupt disabled
        start_run(0, 1, 1, 1, 2, 3, 0, 32'h1001, 32'h2000, 32'h0);
        wait_stop();
        chk("R12 no traffic", 32'(nrd + nwr), 32'd0);
        rd(3'd1, v); chk("R12 error flag", v, 32'h8);
        chk("R13 irq gated by enable", {31'd0, irq}, 32'd0);

        // R9: circular reload, then stop
        start_run(1, 0, 1, 0, 2, 3, 0, 32'h3000, 32'h0F00, 32'h22);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (nwr >= 8) break;
        end
        rd(3'd1, v); chk("R9 complete flag in circular", {31'd0, v[1]}, 32'd1);
        rd(3'd0, v); chk("R9 enable kept", {31'd0, v[0]}, 32'd1);
        chk("R9 irq", {31'd0, irq}, 32'd1);
        wr(3'd0, 32'd0);
        wait_stop();
        saved = nwr;
        repeat (20) @(negedge clk);
        chk("R9 stopped", 32'(nwr), 32'(saved));
        chk("R9 bus released", {31'd0, bus_req}, 32'd0);

        // R13: selective flag clearing
        start_run(0, 1, 1, 2, 2, 4, 0, 32'h500, 32'h900, 32'h6);
        wait_stop();
        rd(3'd1, v); chk("R13 both flags", v, 32'h6);
        chk("R13 irq set", {31'd0, irq}, 32'd1);
        wr(3'd1, 32'h4);
        rd(3'd1, v); chk("R13 complete cleared, half kept", v, 32'h4);
        chk("R13 irq from half", {31'd0, irq}, 32'd1);
        wr(3'd1, 32'h0);
        rd(3'd1, v); chk("R13 all cleared", v, 32'h0);
        chk("R13 irq cleared", {31'd0, irq}, 32'd0);

        // R14: priority field and undefined bits
        wr(3'd0, 32'h0000_6000);
        chk("R14 priority port", {30'd0, chan_prio}, 32'd2);
        rd(3'd0, v); chk("R14 control readback", v, 32'h0000_2000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule